// File: doc/BRIEF.md
# Trimmed Timekeeping Divider

This block turns a square-wave oscillator of nominally 32.768 kHz into a one-per-second timekeeping strobe and a hundred-per-second strobe. The oscillator level is already synchronous to the system clock and runs well below it. Each rising edge of the oscillator is one count. A 3-bit trim code corrects the seconds rate in 10 ppm steps, up to 30 ppm in either direction.

The correction works over a window of 100 seconds. For a magnitude of m steps, the first 33·m seconds of each window are one oscillator count short (positive trim) or one count long (negative trim). Inside each second, the hundred sub-periods are 328 or 327 counts long. The long ones come first, and their number is adjusted so that the last sub-period ends exactly on the seconds boundary.

A registered frequency output can be held low or can follow one of three sources: a 1 Hz square wave, a 100 Hz square wave, or the oscillator itself. All counts are parameters: the oscillator rate, the sub-ticks per second, the window length, and the counts added or removed per step.

Top module: `rtc_trim_divider`

## Requirements
- R1: While the synchronous reset is held, and after it is released until the first oscillator edge is counted, `tick1Hz`, `tick100Hz` and `freqOut` are low. The second, sub-period and window position all restart at zero.
- R2: With a zero trim, every second spans exactly OSC_HZ oscillator rising edges.
- R3: A positive trim swallows counts. The trim field bits [1:0] give the magnitude: 10 → 1 step, 01 → 2 steps, 11 → 3 steps. The first CYC_PER_STEP × magnitude seconds of each window are then OSC_HZ − 1 edges long.
- R4: A negative trim inserts counts. Bit 2 set is the negative sign, and the magnitude mapping is the same as in R3. The first CYC_PER_STEP × magnitude seconds of each window are then OSC_HZ + 1 edges long.
- R5: Code 100 means zero, exactly like code 000.
- R6: The trim input is sampled on the edge that closes a second, and it governs the whole next second. Changes in mid-second have no effect on the second in progress.
- R7: The window is WINDOW_SEC seconds long and restarts from reset. Seconds at window positions at or beyond CYC_PER_STEP × magnitude are nominal.
- R8: Every second holds SUB_PER_SEC sub-ticks, and the last one coincides with `tick1Hz`. Sub-period k is SHORT+1 edges long if k < BASE_LONG − adj, and SHORT edges long otherwise. Here SHORT = OSC_HZ / SUB_PER_SEC, BASE_LONG = OSC_HZ − SHORT·SUB_PER_SEC, and adj is +1 for a shortened second, −1 for a lengthened one, and 0 otherwise.
- R9: Output select values: 00 gives a constant low; 01 gives one rising edge per second; 10 gives one rising edge per sub-period; 11 gives the oscillator level delayed by two clocks.
- R10: A new select value takes effect only on the next oscillator edge. Until then the output keeps following the previous selection.
- R11: Both ticks are single-cycle pulses, issued one clock after the oscillator edge that completes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstSync | input | 1 | Synchronous reset, active high |
| oscLevel | input | 1 | Oscillator square wave, synchronous to clk |
| trimCode | input | 3 | Sign (bit 2) and magnitude (bits 1:0) of the rate correction |
| outSel | input | 2 | Frequency output source select |
| tick1Hz | output | 1 | One-cycle seconds strobe |
| tick100Hz | output | 1 | One-cycle sub-second strobe |
| freqOut | output | 1 | Registered frequency output |

## Verification
The hardest condition to reach from the ports is a trim change that lands inside a second while the window position sits near the edge of the corrected span. The output must switch exactly at the next boundary, at exactly the right window position. The bench uses a shrunken configuration (205 counts per second, 10 sub-ticks, a 10-second window, 3 counts per step), so many windows fit into a short run. Directed seconds walk through every code, including both zero encodings. A random phase then changes the trim at random cycles within seconds and jitters the oscillator period. Every second and every sub-period length is compared against a model that counts oscillator edges.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;

  typedef enum logic [1:0] {
    OUT_OFF = 2'b00,
    OUT_SEC = 2'b01,
    OUT_SUB = 2'b10,
    OUT_OSC = 2'b11
  } outMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic longPeriod;  // current sub-period takes one extra count
    logic selSec;
    logic selSub;
    logic selOsc;
  } ctrlStrobe_t;

  // signed step count of a trim code; bit1 weighs 1, bit0 weighs 2
  function automatic int trimSteps(input logic [2:0] code);
    int mag;
    mag = int'({code[0], code[1]});
    return code[2] ? -mag : mag;
  endfunction

endpackage

// File: rtl/rtcdiv_ctrl.sv
module rtcdiv_ctrl
  import rtcdiv_pkg::*;
#(
  parameter int SUB_PER_SEC  = 100,
  parameter int WINDOW_SEC   = 100,
  parameter int CYC_PER_STEP = 33,
  parameter int BASE_LONG    = 68,
  parameter int SUB_W        = 7,
  parameter int WIN_W        = 7
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic [2:0]       trimCode,
  input  logic [1:0]       outSel,
  input  logic             oscTick,
  input  logic             secEnd,
  input  logic [SUB_W-1:0] subIdx,
  output ctrlStrobe_t      strobe,
  output outMode_e         selMode
);

  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_SEC - 1);

  logic [2:0]       trimReg;
  logic [WIN_W-1:0] winIdx;
  outMode_e         selReg;

  int  steps;
  int  mag;
  int  adj;
  int  nLong;
  logic corrActive;

  always_ff @(posedge clk) begin
    if (rstSync) begin
      trimReg <= trimCode;
      winIdx  <= '0;
      selReg  <= OUT_OFF;
    end else begin
      if (secEnd) begin
        trimReg <= trimCode;
        winIdx  <= (winIdx == WIN_LAST) ? '0 : winIdx + 1'b1;
      end
      if (oscTick) selReg <= outMode_e'(outSel);
    end
  end

  always_comb begin
    steps      = trimSteps(trimReg);
    mag        = (steps < 0) ? -steps : steps;
    corrActive = int'(winIdx) < CYC_PER_STEP * mag;
    if (!corrActive)    adj = 0;
    else if (steps > 0) adj = 1;
    else                adj = -1;
    nLong = BASE_LONG - adj;
    strobe.longPeriod = int'(subIdx) < nLong;
    strobe.selSec     = (selReg == OUT_SEC);
    strobe.selSub     = (selReg == OUT_SUB);
    strobe.selOsc     = (selReg == OUT_OSC);
  end

  assign selMode = selReg;

endmodule

// File: rtl/rtcdiv_dp.sv
module rtcdiv_dp
  import rtcdiv_pkg::*;
#(
  parameter int SUB_PER_SEC = 100,
  parameter int SHORT_LEN   = 327,
  parameter int SUB_W       = 7,
  parameter int CNT_W       = 9
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic             oscLevel,
  input  ctrlStrobe_t      strobe,
  output logic             oscTick,
  output logic             secEnd,
  output logic [SUB_W-1:0] subIdx,
  output logic             tick1Hz,
  output logic             tick100Hz,
  output logic             freqOut
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_PER_SEC - 1);

  logic             oscPrev;
  logic [CNT_W-1:0] subCnt;
  logic             subEnd;
  logic             waveSec;
  logic             waveSub;
  logic             nextOut;
  int               lastCnt;

  always_comb begin
    oscTick = oscLevel & ~oscPrev;
    lastCnt = strobe.longPeriod ? SHORT_LEN : SHORT_LEN - 1;
    subEnd  = oscTick && (int'(subCnt) == lastCnt);
    secEnd  = subEnd && (subIdx == SUB_LAST);
    waveSec = int'(subIdx) < SUB_PER_SEC / 2;
    waveSub = int'(subCnt) < SHORT_LEN / 2;
    if (strobe.selOsc)      nextOut = oscPrev;
    else if (strobe.selSec) nextOut = waveSec;
    else if (strobe.selSub) nextOut = waveSub;
    else                    nextOut = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rstSync) begin
      oscPrev   <= 1'b0;
      subCnt    <= '0;
      subIdx    <= '0;
      tick1Hz   <= 1'b0;
      tick100Hz <= 1'b0;
      freqOut   <= 1'b0;
    end else begin
      oscPrev   <= oscLevel;
      tick100Hz <= subEnd;
      tick1Hz   <= secEnd;
      freqOut   <= nextOut;
      if (oscTick) subCnt <= subEnd ? '0 : subCnt + 1'b1;
      if (subEnd)  subIdx <= secEnd ? '0 : subIdx + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtcdiv_pkg::*;
#(
  parameter int OSC_HZ       = 32768,
  parameter int SUB_PER_SEC  = 100,
  parameter int WINDOW_SEC   = 100,
  parameter int CYC_PER_STEP = 33
) (
  input  logic       clk,
  input  logic       rstSync,
  input  logic       oscLevel,
  input  logic [2:0] trimCode,
  input  logic [1:0] outSel,
  output logic       tick1Hz,
  output logic       tick100Hz,
  output logic       freqOut
);

  localparam int SHORT_LEN = OSC_HZ / SUB_PER_SEC;
  localparam int BASE_LONG = OSC_HZ - SHORT_LEN * SUB_PER_SEC;
  localparam int SUB_W     = $clog2(SUB_PER_SEC);
  localparam int WIN_W     = $clog2(WINDOW_SEC);
  localparam int CNT_W     = $clog2(SHORT_LEN + 1);

  ctrlStrobe_t      strobe;
  outMode_e         selMode;
  logic             oscTick;
  logic             secEnd;
  logic [SUB_W-1:0] subIdx;

  rtcdiv_ctrl #(
    .SUB_PER_SEC (SUB_PER_SEC),
    .WINDOW_SEC  (WINDOW_SEC),
    .CYC_PER_STEP(CYC_PER_STEP),
    .BASE_LONG   (BASE_LONG),
    .SUB_W       (SUB_W),
    .WIN_W       (WIN_W)
  ) u_ctrl (
    .clk     (clk),
    .rstSync (rstSync),
    .trimCode(trimCode),
    .outSel  (outSel),
    .oscTick (oscTick),
    .secEnd  (secEnd),
    .subIdx  (subIdx),
    .strobe  (strobe),
    .selMode (selMode)
  );

  rtcdiv_dp #(
    .SUB_PER_SEC(SUB_PER_SEC),
    .SHORT_LEN  (SHORT_LEN),
    .SUB_W      (SUB_W),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstSync  (rstSync),
    .oscLevel (oscLevel),
    .strobe   (strobe),
    .oscTick  (oscTick),
    .secEnd   (secEnd),
    .subIdx   (subIdx),
    .tick1Hz  (tick1Hz),
    .tick100Hz(tick100Hz),
    .freqOut  (freqOut)
  );

endmodule

// File: rtl/rtcdiv_checker.sv
module rtcdiv_checker (
  input logic       clk,
  input logic       rstSync,
  input logic       oscLevel,
  input logic       tick1Hz,
  input logic       tick100Hz,
  input logic       freqOut,
  input logic [1:0] selMode
);

  p_sec_pulse_r11: assert property (@(posedge clk) disable iff (rstSync)
    tick1Hz |=> !tick1Hz);

  p_sub_pulse_r11: assert property (@(posedge clk) disable iff (rstSync)
    tick100Hz |=> !tick100Hz);

  p_sec_on_sub_r8: assert property (@(posedge clk) disable iff (rstSync)
    tick1Hz |-> tick100Hz);

  p_tick_after_edge_r2: assert property (@(posedge clk) disable iff (rstSync)
    tick100Hz |-> ($past(oscLevel) && !$past(oscLevel, 2)));

  p_off_low_r9: assert property (@(posedge clk) disable iff (rstSync)
    (selMode == 2'b00) |=> !freqOut);

  p_osc_follow_r9: assert property (@(posedge clk) disable iff (rstSync)
    (selMode == 2'b11) |=> (freqOut == $past(oscLevel, 2)));

  p_sel_on_edge_r10: assert property (@(posedge clk) disable iff (rstSync)
    !$stable(selMode) |-> ($past(oscLevel) && !$past(oscLevel, 2)));

endmodule

bind rtc_trim_divider rtcdiv_checker u_chk (
  .clk      (clk),
  .rstSync  (rstSync),
  .oscLevel (oscLevel),
  .tick1Hz  (tick1Hz),
  .tick100Hz(tick100Hz),
  .freqOut  (freqOut),
  .selMode  (selMode)
);

// File: tb/tb_rtc_trim_divider.sv
module tb_rtc_trim_divider;

  localparam int OSC   = 205;
  localparam int SUB   = 10;
  localparam int WIN   = 10;
  localparam int CYC   = 3;
  localparam int SHORT = OSC / SUB;
  localparam int BASE  = OSC - SHORT * SUB;
  localparam int NSEC  = 60;

  logic       clk = 1'b0;
  logic       rstSync;
  logic       oscLevel;
  logic [2:0] trimCode;
  logic [1:0] outSel;
  logic       tick1Hz, tick100Hz, freqOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_trim_divider #(
    .OSC_HZ(OSC), .SUB_PER_SEC(SUB), .WINDOW_SEC(WIN), .CYC_PER_STEP(CYC)
  ) dut (
    .clk(clk), .rstSync(rstSync), .oscLevel(oscLevel), .trimCode(trimCode),
    .outSel(outSel), .tick1Hz(tick1Hz), .tick100Hz(tick100Hz), .freqOut(freqOut)
  );

  function automatic int stepsOf(input logic [2:0] c);
    case (c)
      3'b000: return 0;  3'b010: return 1;  3'b001: return 2;  3'b011: return 3;
      3'b100: return 0;  3'b110: return -1; 3'b101: return -2; default: return -3;
    endcase
  endfunction

  function automatic int adjOf(input int s, input logic [2:0] c);
    int st;
    st = stepsOf(c);
    if (st == 0) return 0;
    if (st > 0) return (s < CYC * st) ? 1 : 0;
    return (s < -CYC * st) ? -1 : 0;
  endfunction

  function automatic int expSec(input int s, input logic [2:0] c);
    return OSC - adjOf(s, c);
  endfunction

  function automatic int expSub(input int s, input logic [2:0] c, input int k);
    return (k < BASE - adjOf(s, c)) ? SHORT + 1 : SHORT;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int edgesDriven, lastSec, lastSub, secIdx, subK, secCount, rises;
  int lowLeft, cycInSec, modeCheck, pendingMode, prevMode, edgesAtChange, wd;
  bit midNext, midCur, prevFo, prevT1, prevT100, guardOff;
  logic lev1, lev2;
  logic [2:0] activeTrim;
  string tag;

  initial begin
    rstSync = 1'b1; oscLevel = 1'b0; trimCode = 3'b011; outSel = 2'b00;
    edgesDriven = 0; lastSec = 0; lastSub = 0; secIdx = 0; subK = 0; secCount = 0;
    rises = 0; lowLeft = 2; cycInSec = 0; modeCheck = -1; pendingMode = 0; prevMode = 0;
    edgesAtChange = 0; wd = 0; midNext = 0; midCur = 0; prevFo = 0; prevT1 = 0;
    prevT100 = 0; guardOff = 0; lev1 = 0; lev2 = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low while reset held
    check(!tick1Hz && !tick100Hz && !freqOut, "R1 reset outputs", int'(tick1Hz | tick100Hz | freqOut), 0);
    rstSync = 1'b0;
    activeTrim = trimCode;
    @(negedge clk);
    check(!tick1Hz && !tick100Hz && !freqOut, "R1 after release", int'(tick1Hz | tick100Hz | freqOut), 0);

    while (secCount < NSEC && wd < 5000) begin
      @(negedge clk);
      wd++; cycInSec++;
      // ---- sample ----
      if (modeCheck == 3) check(freqOut == lev2, "R9 oscillator follow", int'(freqOut), int'(lev2));
      if (modeCheck == 0) check(!freqOut, "R9 output off", int'(freqOut), 0);
      if (guardOff) begin
        if (edgesDriven == edgesAtChange)
          check(!freqOut, "R10 select waits for edge", int'(freqOut), 0);
        else guardOff = 0;
      end
      if (freqOut && !prevFo) rises++;
      prevFo = freqOut;
      if (tick100Hz) begin
        check(!prevT100, "R11 sub pulse width", 1, 0);
        check(edgesDriven - lastSub == expSub(secIdx, activeTrim, subK), "R8 sub-period length",
              edgesDriven - lastSub, expSub(secIdx, activeTrim, subK));
        subK++;
        lastSub = edgesDriven;
      end
      prevT100 = tick100Hz;
      if (tick1Hz) begin
        wd = 0;
        check(!prevT1, "R11 second pulse width", 1, 0);
        check(subK == SUB, "R8 sub-ticks per second", subK, SUB);
        if (midCur) tag = "R6 boundary-sampled trim";
        else if (stepsOf(activeTrim) == 0) tag = activeTrim[2] ? "R5 second zero code" : "R2 nominal";
        else if (adjOf(secIdx, activeTrim) == 0) tag = "R7 window tail nominal";
        else if (stepsOf(activeTrim) > 0) tag = "R3 swallowed count";
        else tag = "R4 inserted count";
        check(edgesDriven - lastSec == expSec(secIdx, activeTrim), tag,
              edgesDriven - lastSec, expSec(secIdx, activeTrim));
        if (modeCheck == 1) check(rises == 1, "R9 seconds wave rises", rises, 1);
        if (modeCheck == 2) check(rises == SUB, "R9 sub wave rises", rises, SUB);
        // advance model
        secIdx = (secIdx + 1) % WIN;
        activeTrim = trimCode;
        midCur = midNext; midNext = 0;
        subK = 0; lastSec = edgesDriven; rises = 0; cycInSec = 0;
        secCount++;
        modeCheck = pendingMode;
        // directed trim schedule, then random per second
        case (secCount)
          8:  trimCode = 3'b111;
          18: trimCode = 3'b100;
          22: trimCode = 3'b000;
          26: trimCode = 3'b010;
          30: trimCode = 3'b110;
          34: trimCode = 3'b001;
          38: trimCode = 3'b101;
          default: if (secCount >= 42) trimCode = 3'($urandom);
        endcase
        if (secCount % 3 == 0) begin
          prevMode = int'(outSel);
          outSel = 2'((secCount / 3) % 4);
          pendingMode = int'(outSel);
          modeCheck = -1;
          if (prevMode == 0 && outSel != 2'b00) begin
            guardOff = 1;
            edgesAtChange = edgesDriven;
          end
        end
      end
      prevT1 = tick1Hz;
      // ---- drive ----
      if (secCount >= 42 && (($urandom % 400) == 0 || (secCount == 44 && cycInSec == 200))) begin
        trimCode = 3'($urandom);
        midNext = 1;  // R6: change lands inside a second
      end
      if (oscLevel) begin
        oscLevel = 1'b0;
        lowLeft = (secCount < 20) ? 1 : int'($urandom % 3) + 1;
      end else begin
        lowLeft--;
        if (lowLeft <= 0) begin
          oscLevel = 1'b1;
          edgesDriven++;
        end
      end
      lev2 = lev1;
      lev1 = oscLevel;
    end

    if (wd >= 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", secCount, NSEC);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule